// File: doc/BRIEF.md
# Paged Non-Volatile Row Programming Controller

This block sits between a processor data bus and a small non-volatile byte array. The array is split into pages of 64 bytes that share one 6-bit address window, and each page is split into rows of eight bytes. A one-hot page select input picks the page. An 8-bit control register holds four write-only control bits and one read-only busy flag. Software uses the control register to power the array down, to allow programming, and to choose how bytes are written.

In byte mode, one array write with programming allowed copies that byte into the row buffer and starts a timed programming cycle. In row mode, software first sets the row-mode bit, which clears the eight row latches. The first accepted array write fixes the row and the page. Every later write to that row fills one latch. Setting the start bit then programs, in one timed cycle, only the bytes that were loaded. A write that lands outside the fixed row raises a sticky error flag and is dropped.

The controller is a three-state machine:
- `ST_IDLE`: byte mode, and normal reads.
- `ST_LOAD`: row mode, where latches are being filled.
- `ST_PROG`: a programming cycle is running.

The transitions are:
- `ST_IDLE`→`ST_LOAD`: a register write sets the row-mode bit.
- `ST_IDLE`→`ST_PROG`: an accepted byte write arrives while programming is allowed.
- `ST_LOAD`→`ST_IDLE`: a register write clears the row-mode bit, which abandons the load.
- `ST_LOAD`→`ST_PROG`: a valid start request arrives.
- `ST_PROG`→`ST_IDLE`: the cycle timer expires. The loaded bytes are committed on that same edge.

Top module: `eeprom_row_ctrl`

## Requirements
- R1: After reset, `reg_rdata` reads 00h, `busy` and `row_err` are low, and every array byte reads FFh.
- R2: `reg_rdata` shows the busy flag in bit 1. Bits 7..2 and bit 0 always read zero, because bit 6 (power-down), bit 3 (start), bit 2 (row mode) and bit 0 (program enable) are write-only.
- R3: An array access is void while power-down is set, or while `page_sel` is not exactly one-hot (bit i selects page i). A void read returns 00h and a void write changes nothing.
- R4: In `ST_IDLE`, an accepted array write with program enable set raises `busy` on the next cycle. `busy` then stays high for exactly PROG_CYCLES cycles, and the one addressed byte takes the new value when `busy` falls.
- R5: An array write made while program enable is low starts no cycle and changes no byte.
- R6: While `busy` is high, register writes are ignored, array reads return 00h and array writes are dropped. The running cycle completes unchanged.
- R7: Setting the row-mode bit clears all eight row latches and clears `row_err`. The first accepted write that follows fixes the row (address bits 5..3) and the page. Address bits 2..0 pick the byte within the row.
- R8: A start request starts a cycle only if program enable was already set, row mode is active, and the same write keeps row mode (bit 2) and program enable (bit 0) set. Any other start request leaves the controller idle.
- R9: A row-mode cycle programs only the bytes loaded since row mode was entered. The other bytes in the row keep their old values.
- R10: Row mode ends by itself when the cycle finishes, so the next enabled write runs as a byte-mode write. Clearing the row-mode bit before start discards the latches and leaves the array unchanged.
- R11: In row mode, a write to a different row or page sets `row_err` and is not committed. `row_err` stays set until row mode is entered again.
- R12: In row mode, array reads return 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| page_sel | input | NPAGES | One-hot page select; bit i selects page i |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read value |
| mem_wr | input | 1 | Array write strobe (ignored when `reg_wr` is high) |
| mem_rd | input | 1 | Array read strobe |
| mem_addr | input | log2(PAGE_BYTES) | Byte address within the page window |
| mem_wdata | input | DW | Array write data |
| mem_rdata | output | DW | Array read data; 00h when the read is void or `mem_rd` is low |
| busy | output | 1 | Programming cycle in progress |
| row_err | output | 1 | Sticky flag for a write outside the fixed row |

## Verification
The bench builds the block with PROG_CYCLES set to 5 and keeps the default two pages of 64 bytes. A short cycle lets each busy window be probed before, during and after it. It also lets several hundred random register, write and read operations run through complete cycles. With two pages, the bench can reach the page-mismatch error, the all-ones page select and the empty page select, as well as row-mode loads that cross pages.

// File: rtl/eerw_pkg.sv
package eerw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_PROG = 2'd2
    } eerw_state_t;

    localparam int CB_OFF   = 6;
    localparam int CB_START = 3;
    localparam int CB_PMODE = 2;
    localparam int CB_BUSY  = 1;
    localparam int CB_EN    = 0;
endpackage

// File: rtl/eerw_timer.sv
module eerw_timer #(
    parameter int CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (start)
            cnt_q <= CW'(CYCLES);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);
    assign done = (cnt_q == CW'(1));
endmodule

// File: rtl/eerw_row_buf.sv
module eerw_row_buf #(
    parameter int NBYTES = 8,
    parameter int DW     = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clr,
    input  logic                      wr,
    input  logic [$clog2(NBYTES)-1:0] idx,
    input  logic [DW-1:0]             wdata,
    output logic [NBYTES*DW-1:0]      data,
    output logic [NBYTES-1:0]         mask
);
    localparam int IW = $clog2(NBYTES);

    for (genvar i = 0; i < NBYTES; i++) begin : g_lat
        logic hit;
        assign hit = wr && (idx == IW'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mask[i]           <= 1'b0;
                data[i*DW +: DW]  <= '0;
            end else begin
                if (clr)
                    mask[i] <= hit;
                else if (hit)
                    mask[i] <= 1'b1;
                if (hit)
                    data[i*DW +: DW] <= wdata;
            end
        end
    end
endmodule

// File: rtl/eerw_store.sv
module eerw_store #(
    parameter int NPAGES     = 2,
    parameter int PAGE_BYTES = 64,
    parameter int ROW_BYTES  = 8,
    parameter int DW         = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          commit,
    input  logic [$clog2(NPAGES)-1:0]     cpage,
    input  logic [$clog2(PAGE_BYTES)-$clog2(ROW_BYTES)-1:0] crow,
    input  logic [ROW_BYTES-1:0]          cmask,
    input  logic [ROW_BYTES*DW-1:0]       cdata,
    input  logic [$clog2(NPAGES)-1:0]     rpage,
    input  logic [$clog2(PAGE_BYTES)-1:0] raddr,
    output logic [DW-1:0]                 rdata
);
    localparam int PW    = $clog2(NPAGES);
    localparam int AW    = $clog2(PAGE_BYTES);
    localparam int RW    = AW - $clog2(ROW_BYTES);
    localparam int NROWS = PAGE_BYTES / ROW_BYTES;
    localparam int TOTAL = NPAGES * PAGE_BYTES;

    logic [DW-1:0] cells [TOTAL];

    for (genvar p = 0; p < NPAGES; p++) begin : g_page
        for (genvar r = 0; r < NROWS; r++) begin : g_row
            for (genvar b = 0; b < ROW_BYTES; b++) begin : g_byte
                localparam int CI = p*PAGE_BYTES + r*ROW_BYTES + b;
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n)
                        cells[CI] <= {DW{1'b1}};
                    else if (commit && cmask[b] && (cpage == PW'(p)) && (crow == RW'(r)))
                        cells[CI] <= cdata[b*DW +: DW];
                end
            end
        end
    end

    assign rdata = cells[{rpage, raddr}];
endmodule

// File: rtl/eeprom_row_ctrl.sv
module eeprom_row_ctrl
    import eerw_pkg::*;
#(
    parameter int NPAGES      = 2,
    parameter int PAGE_BYTES  = 64,
    parameter int ROW_BYTES   = 8,
    parameter int DW          = 8,
    parameter int PROG_CYCLES = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NPAGES-1:0]             page_sel,
    input  logic                          reg_wr,
    input  logic [7:0]                    reg_wdata,
    output logic [7:0]                    reg_rdata,
    input  logic                          mem_wr,
    input  logic                          mem_rd,
    input  logic [$clog2(PAGE_BYTES)-1:0] mem_addr,
    input  logic [DW-1:0]                 mem_wdata,
    output logic [DW-1:0]                 mem_rdata,
    output logic                          busy,
    output logic                          row_err
);
    localparam int AW = $clog2(PAGE_BYTES);
    localparam int BW = $clog2(ROW_BYTES);
    localparam int RW = AW - BW;
    localparam int PW = $clog2(NPAGES);

    eerw_state_t state_q, state_d;

    logic          off_q, en_q, rowv_q, err_q;
    logic [RW-1:0] row_q;
    logic [PW-1:0] page_q;
    logic [PW-1:0] page_idx;
    logic          page_ok, acc_ok, row_hit, mem_go;
    logic          buf_clr, buf_wr, take_row, tmr_start, set_err, clr_err, commit;
    logic          tmr_done;
    logic [ROW_BYTES*DW-1:0] lat_data;
    logic [ROW_BYTES-1:0]    lat_mask;
    logic [PW-1:0] cpage;
    logic [RW-1:0] crow;
    logic [DW-1:0] st_rdata;
    logic          unused_wbits;

    assign unused_wbits = ^{reg_wdata[7], reg_wdata[5:4], reg_wdata[1]};

    always_comb begin
        page_idx = '0;
        for (int i = 0; i < NPAGES; i++)
            if (page_sel[i]) page_idx = PW'(i);
    end

    assign page_ok = $onehot(page_sel);
    assign acc_ok  = page_ok && !off_q;
    assign mem_go  = mem_wr && !reg_wr && acc_ok;
    assign row_hit = !rowv_q || ((mem_addr[AW-1:BW] == row_q) && (page_idx == page_q));

    // Next-state process
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (reg_wr && reg_wdata[CB_PMODE])
                    state_d = ST_LOAD;
                else if (mem_go && en_q)
                    state_d = ST_PROG;
            end
            ST_LOAD: begin
                if (reg_wr && !reg_wdata[CB_PMODE])
                    state_d = ST_IDLE;
                else if (reg_wr && reg_wdata[CB_START] && reg_wdata[CB_EN] && en_q)
                    state_d = ST_PROG;
            end
            ST_PROG: begin
                if (tmr_done)
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Strobe (output) process
    always_comb begin
        buf_clr   = 1'b0;
        buf_wr    = 1'b0;
        take_row  = 1'b0;
        tmr_start = 1'b0;
        set_err   = 1'b0;
        clr_err   = 1'b0;
        commit    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (reg_wr && reg_wdata[CB_PMODE]) begin
                    buf_clr = 1'b1;
                    clr_err = 1'b1;
                end else if (mem_go && en_q) begin
                    buf_clr   = 1'b1;
                    buf_wr    = 1'b1;
                    take_row  = 1'b1;
                    tmr_start = 1'b1;
                end
            end
            ST_LOAD: begin
                if (reg_wr) begin
                    if (reg_wdata[CB_PMODE] && reg_wdata[CB_START] && reg_wdata[CB_EN] && en_q)
                        tmr_start = 1'b1;
                end else if (mem_go) begin
                    if (row_hit) begin
                        buf_wr   = 1'b1;
                        take_row = 1'b1;
                    end else begin
                        set_err = 1'b1;
                    end
                end
            end
            ST_PROG: commit = tmr_done;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_q  <= 1'b0;
            en_q   <= 1'b0;
            rowv_q <= 1'b0;
            err_q  <= 1'b0;
            row_q  <= '0;
            page_q <= '0;
        end else begin
            if (reg_wr && state_q != ST_PROG) begin
                off_q <= reg_wdata[CB_OFF];
                en_q  <= reg_wdata[CB_EN];
            end
            if (take_row) begin
                rowv_q <= 1'b1;
                row_q  <= mem_addr[AW-1:BW];
                page_q <= page_idx;
            end else if (buf_clr) begin
                rowv_q <= 1'b0;
            end
            if (clr_err)      err_q <= 1'b0;
            else if (set_err) err_q <= 1'b1;
        end
    end

    eerw_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .busy  (busy),
        .done  (tmr_done)
    );

    eerw_row_buf #(.NBYTES(ROW_BYTES), .DW(DW)) u_rowbuf (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (buf_clr),
        .wr    (buf_wr),
        .idx   (mem_addr[BW-1:0]),
        .wdata (mem_wdata),
        .data  (lat_data),
        .mask  (lat_mask)
    );

    assign cpage = page_q;
    assign crow  = row_q;

    eerw_store #(
        .NPAGES(NPAGES), .PAGE_BYTES(PAGE_BYTES), .ROW_BYTES(ROW_BYTES), .DW(DW)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .commit (commit),
        .cpage  (cpage),
        .crow   (crow),
        .cmask  (lat_mask),
        .cdata  (lat_data),
        .rpage  (page_idx),
        .raddr  (mem_addr),
        .rdata  (st_rdata)
    );

    always_comb begin
        reg_rdata          = '0;
        reg_rdata[CB_BUSY] = busy;
    end

    assign mem_rdata = (mem_rd && acc_ok && state_q == ST_IDLE) ? st_rdata : '0;
    assign row_err   = err_q;
endmodule

// File: rtl/eerw_chk.sv
module eerw_chk #(
    parameter int NPAGES      = 2,
    parameter int DW          = 8,
    parameter int PROG_CYCLES = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              reg_wr,
    input logic              mem_wr,
    input logic              mem_rd,
    input logic [NPAGES-1:0] page_sel,
    input logic [7:0]        reg_rdata,
    input logic [DW-1:0]     mem_rdata,
    input logic              row_err,
    input logic              en_q,
    input logic              in_idle
);
    int hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    hi_cnt <= 0;
        else if (busy) hi_cnt <= hi_cnt + 1;
        else           hi_cnt <= 0;
    end

    // R4
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> hi_cnt == PROG_CYCLES);

    // R4
    busy_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> hi_cnt < PROG_CYCLES);

    // R6
    busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(reg_wr || mem_wr));

    // R5
    no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_idle && !reg_wr && mem_wr && !en_q) |=> !busy);

    // R2
    reg_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata & 8'hFD) == 8'h00);

    // R6
    busy_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mem_rd) |-> mem_rdata == '0);

    // R3
    void_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !$onehot(page_sel)) |-> mem_rdata == '0);

    // R11
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (row_err && !reg_wr) |=> row_err);
endmodule

bind eeprom_row_ctrl eerw_chk #(
    .NPAGES(NPAGES), .DW(DW), .PROG_CYCLES(PROG_CYCLES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .reg_wr    (reg_wr),
    .mem_wr    (mem_wr),
    .mem_rd    (mem_rd),
    .page_sel  (page_sel),
    .reg_rdata (reg_rdata),
    .mem_rdata (mem_rdata),
    .row_err   (row_err),
    .en_q      (en_q),
    .in_idle   (state_q == eerw_pkg::ST_IDLE)
);

// File: tb/eeprom_row_ctrl_test.sv
module eeprom_row_ctrl_test;
    localparam int NCYC = 5;
    localparam int WD   = 50000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] page_sel = 2'b00;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       mem_wr = 1'b0;
    logic       mem_rd = 1'b0;
    logic [5:0] mem_addr = 6'd0;
    logic [7:0] mem_wdata = 8'h00;
    logic [7:0] mem_rdata;
    logic       busy;
    logic       row_err;

    always #5 clk = ~clk;

    eeprom_row_ctrl #(.PROG_CYCLES(NCYC)) uut (
        .clk(clk), .rst_n(rst_n), .page_sel(page_sel),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_wr(mem_wr), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .busy(busy), .row_err(row_err)
    );

    int    vectors = 0;
    int    miscompares = 0;
    int    cyc = 0;
    string cur_req = "R1";

    // Behavioural reference model
    int m_mem [128];
    int lat_d [8];
    bit lat_m [8];
    bit m_off = 0, m_en = 0, m_pm = 0, m_rowv = 0, m_err = 0;
    int m_cnt = 0, m_row = 0, m_page = 0;
    bit old_en;

    initial for (int i = 0; i < 128; i++) m_mem[i] = 255;

    function automatic bit pvalid(input logic [1:0] ps);
        return (ps == 2'b01) || (ps == 2'b10);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 128; i++) m_mem[i] = 255;
            m_off = 0; m_en = 0; m_pm = 0; m_rowv = 0; m_err = 0; m_cnt = 0;
        end else if (m_cnt > 0) begin
            m_cnt = m_cnt - 1;
            if (m_cnt == 0) begin
                for (int i = 0; i < 8; i++)
                    if (lat_m[i]) m_mem[m_page*64 + m_row*8 + i] = lat_d[i];
                m_pm = 0;
            end
        end else if (reg_wr) begin
            old_en = m_en;
            m_off  = reg_wdata[6];
            m_en   = reg_wdata[0];
            if (!m_pm) begin
                if (reg_wdata[2]) begin
                    m_pm = 1; m_rowv = 0; m_err = 0;
                    for (int i = 0; i < 8; i++) lat_m[i] = 0;
                end
            end else if (!reg_wdata[2]) begin
                m_pm = 0;
            end else if (reg_wdata[3] && reg_wdata[0] && old_en) begin
                m_cnt = NCYC;
            end
        end else if (mem_wr && pvalid(page_sel) && !m_off) begin
            if (!m_pm) begin
                if (m_en) begin
                    for (int i = 0; i < 8; i++) lat_m[i] = 0;
                    lat_m[mem_addr % 8] = 1;
                    lat_d[mem_addr % 8] = mem_wdata;
                    m_row = mem_addr / 8; m_page = (page_sel == 2'b10);
                    m_cnt = NCYC;
                end
            end else if (!m_rowv || (mem_addr / 8 == m_row && (page_sel == 2'b10) == m_page)) begin
                lat_m[mem_addr % 8] = 1;
                lat_d[mem_addr % 8] = mem_wdata;
                m_rowv = 1; m_row = mem_addr / 8; m_page = (page_sel == 2'b10);
            end else begin
                m_err = 1;
            end
        end
    end

    task automatic cmp(input string sig, input int got, input int exp);
        vectors++;
        if (got != exp) begin
            miscompares++;
            $display("FAIL %s %s got %0h exp %0h at cycle %0d", cur_req, sig, got, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            int eb, er;
            eb = (m_cnt > 0);
            er = (mem_rd && pvalid(page_sel) && !m_off && !eb && !m_pm)
                 ? m_mem[(page_sel == 2'b10)*64 + mem_addr] : 0;
            cmp("busy", busy, eb);
            cmp("reg_rdata(R2)", reg_rdata, eb ? 2 : 0);
            cmp("mem_rdata", mem_rdata, er);
            cmp("row_err", row_err, m_err);
        end
    end

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WD) begin
            miscompares++;
            $display("FAIL watchdog expired got %0d exp <%0d", cyc, WD);
            summary();
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr_reg(input logic [7:0] d);
        reg_wr = 1'b1; reg_wdata = d; tick(); reg_wr = 1'b0;
    endtask

    task automatic wr_mem(input logic [1:0] ps, input int a, input logic [7:0] d);
        page_sel = ps; mem_addr = a[5:0]; mem_wdata = d; mem_wr = 1'b1; tick(); mem_wr = 1'b0;
    endtask

    task automatic rd_mem(input logic [1:0] ps, input int a);
        page_sel = ps; mem_addr = a[5:0]; mem_rd = 1'b1; tick(); mem_rd = 1'b0;
    endtask

    task automatic settle();
        repeat (NCYC + 2) tick();
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        cur_req = "R1 reset";
        for (int a = 0; a < 64; a += 9) begin rd_mem(2'b01, a); rd_mem(2'b10, a); end

        cur_req = "R3 void";
        wr_reg(8'h01);
        wr_mem(2'b00, 3, 8'h11);
        wr_mem(2'b11, 4, 8'h22);
        settle();
        rd_mem(2'b00, 3); rd_mem(2'b11, 4); rd_mem(2'b01, 3); rd_mem(2'b01, 4);
        wr_reg(8'h41);
        wr_mem(2'b01, 6, 8'h33);
        rd_mem(2'b01, 6);
        settle();
        wr_reg(8'h01);
        rd_mem(2'b01, 6);

        cur_req = "R5 enable low";
        wr_reg(8'h00);
        wr_mem(2'b01, 5, 8'h44);
        settle();
        rd_mem(2'b01, 5);

        cur_req = "R4 byte mode";
        wr_reg(8'h01);
        wr_mem(2'b01, 5, 8'hAA);
        cur_req = "R6 during busy";
        wr_reg(8'h04);
        rd_mem(2'b01, 5);
        wr_mem(2'b10, 9, 8'h55);
        settle();
        cur_req = "R4 byte readback";
        rd_mem(2'b01, 5); rd_mem(2'b01, 4); rd_mem(2'b10, 9);

        cur_req = "R7 row entry";
        wr_reg(8'h05);
        cur_req = "R12 read in row mode";
        rd_mem(2'b10, 8'h18);
        cur_req = "R7 load";
        wr_mem(2'b10, 8'h18, 8'hC0);
        wr_mem(2'b10, 8'h1A, 8'hC2);
        cur_req = "R11 wrong row";
        wr_mem(2'b10, 8'h20, 8'hEE);
        wr_mem(2'b01, 8'h1B, 8'hEE);
        cur_req = "R7 load";
        wr_mem(2'b10, 8'h1B, 8'hC3);
        cur_req = "R8 start";
        wr_reg(8'h0D);
        settle();
        cur_req = "R9 readback";
        for (int a = 8'h18; a < 8'h20; a++) rd_mem(2'b10, a);
        rd_mem(2'b10, 8'h20); rd_mem(2'b01, 8'h1B);

        cur_req = "R10 byte after row";
        wr_mem(2'b10, 8'h1C, 8'h7C);
        settle();
        rd_mem(2'b10, 8'h1C);

        cur_req = "R8 start refused";
        wr_reg(8'h00);
        wr_reg(8'h04);
        wr_mem(2'b01, 8'h30, 8'h99);
        wr_reg(8'h0C);
        wr_reg(8'h0D);
        settle();
        cur_req = "R10 abandon";
        wr_reg(8'h01);
        settle();
        rd_mem(2'b01, 8'h30);

        cur_req = "R11 error clears";
        wr_reg(8'h05);
        wr_mem(2'b01, 8'h00, 8'h01);
        wr_mem(2'b01, 8'h08, 8'h02);
        wr_reg(8'h01);
        wr_reg(8'h05);
        wr_reg(8'h01);

        cur_req = "R9/R11 random";
        for (int n = 0; n < 600; n++) begin
            int op;
            op = $urandom % 6;
            case (op)
                0: begin
                    int k;
                    k = $urandom % 8;
                    case (k)
                        0: wr_reg(8'h00); 1: wr_reg(8'h01); 2: wr_reg(8'h04); 3: wr_reg(8'h05);
                        4: wr_reg(8'h0D); 5: wr_reg(8'h0C); 6: wr_reg(8'h41); default: wr_reg(8'h09);
                    endcase
                end
                1, 2: wr_mem(2'($urandom % 4), $urandom % 64, 8'($urandom));
                3, 4: rd_mem(2'($urandom % 4), $urandom % 64);
                default: tick();
            endcase
        end
        settle();
        wr_reg(8'h00);
        for (int a = 0; a < 64; a++) begin rd_mem(2'b01, a); rd_mem(2'b10, a); end

        summary();
    end
endmodule